// File: doc/BRIEF.md
# Hardware Store Request Arbiter

This block arbitrates a single shared, active-low request/busy line that sits in front of an SRAM array backed by nonvolatile cells. An external agent pulls the line low to ask that the array contents be saved. The block waits a set number of cycles, lets any SRAM access already under way finish, and only then starts a save. It starts one only if the array has been written since the last save or restore. While a save of any origin is running, the block itself holds the line low. When the save ends the device stays disabled until the line is seen high again.

The line is split into a sense input, which reads the pin level, and a pull enable, which drives an open-drain pull-down. A two-stage synchronizer samples the sense input. A modelled store engine sits inside the block. It receives a one-cycle start pulse and returns a one-cycle done pulse after a fixed number of cycles. A software save request and a restore-complete strobe come in as plain control pins.

SRAM writes use a valid/ready pair. A write is accepted only in a cycle where `wr_valid_i` and `wr_ready_o` are both high. While `wr_ready_o` is low, the requester must keep `wr_valid_i` and its write pending. A write offered but not accepted has no effect. `wr_ready_o` does not depend on `wr_valid_i`.

Top module: `hw_store_arbiter`

## Requirements
- R1: After the synchronized line goes low, `store_start_o` is not raised for at least `DELAY_CYC` cycles. If the line is seen high again before the save begins, the request is withdrawn: no save starts and `dev_en_o` stays high.
- R2: A line request starts a save only when the dirty flag is set. When the flag is clear, the delay ends without a start pulse and the block goes straight to the disabled wait.
- R3: While `acc_busy_i` is high (an SRAM access in flight), a line-requested save is held off. The save starts in the first cycle after the delay in which `acc_busy_i` is low.
- R4: `wr_ready_o` is low whenever the synchronized line is low or the block is not idle. A write offered then does not set the dirty flag.
- R5: `line_pull_o` (1 = pull the line low) is high for exactly `STORE_CYC` cycles during every save and is low at all other times. The block never drives the line high.
- R6: After a save completes, `dev_en_o` stays low until the synchronized line is high again.
- R7: The dirty flag is set by every accepted write and cleared by save completion or by `recall_done_i`. If a write is accepted in the same cycle as a clear, the write wins.
- R8: In the idle state with the line high, a pulse on `sw_store_i` starts a save whether or not the array is dirty.
- R9: Out of reset, `dev_en_o` and `wr_ready_o` are low until the synchronized line is seen high. A line held low through reset therefore starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_sense_i | input | 1 | Level of the shared request/busy line (1 = high) |
| line_pull_o | output | 1 | Open-drain pull enable, 1 pulls the line low |
| sw_store_i | input | 1 | One-cycle software save request |
| acc_busy_i | input | 1 | An SRAM read or write is in flight |
| wr_valid_i | input | 1 | SRAM write offered |
| wr_ready_o | output | 1 | SRAM write may be accepted this cycle |
| recall_done_i | input | 1 | One-cycle strobe: a restore has completed |
| dev_en_o | output | 1 | Device enabled for SRAM accesses |
| store_start_o | output | 1 | One-cycle start pulse to the store engine |
| store_done_o | output | 1 | One-cycle done pulse from the store engine |

## Verification
The bound checker enforces these rules on every cycle:
- The pull is asserted only while the device is disabled.
- A write is accepted only while the device is enabled and the line is not being pulled.
- A line-requested start needs a dirty array and an idle SRAM.
- Start is a single-cycle pulse.
- A done pulse is always followed by a disabled device.

Only the bench scenarios can show the timing properties: the minimum delay before a start, the exact pull length, and the withdrawal of a request when the line goes high again. They also cover the effects that need a sequence of events: blocked writes and restores leaving no save behind, and a line held low through reset.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_HIGH,
    ST_IDLE,
    ST_DELAY,
    ST_STORE,
    ST_HOLD
  } hsa_state_e;
endpackage

// File: rtl/hsa_line_sync.sv
module hsa_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsa_delay_timer.sv
module hsa_delay_timer #(
  parameter int DELAY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/hsa_store_engine.sv
module hsa_store_engine #(
  parameter int STORE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(STORE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STORE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/hw_store_arbiter.sv
module hw_store_arbiter
  import hsa_pkg::*;
#(
  parameter int DELAY_CYC   = 8,
  parameter int STORE_CYC   = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sense_i,
  output logic line_pull_o,
  input  logic sw_store_i,
  input  logic acc_busy_i,
  input  logic wr_valid_i,
  output logic wr_ready_o,
  input  logic recall_done_i,
  output logic dev_en_o,
  output logic store_start_o,
  output logic store_done_o
);
  hsa_state_e state_q, state_d;
  logic line_hi;
  logic dly_done;
  logic eng_busy;
  logic eng_done;
  logic start_req;
  logic dirty_q;
  logic wr_fire;

  hsa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_sense_i),
    .q_o   (line_hi)
  );

  hsa_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (state_q != ST_DELAY),
    .run_i   (state_q == ST_DELAY),
    .done_o  (dly_done)
  );

  hsa_store_engine #(.STORE_CYC(STORE_CYC)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_req),
    .busy_o  (eng_busy),
    .done_o  (eng_done)
  );

  always_comb begin
    state_d   = state_q;
    start_req = 1'b0;
    unique case (state_q)
      ST_WAIT_HIGH, ST_HOLD: begin
        if (line_hi) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!line_hi) begin
          state_d = ST_DELAY;
        end else if (sw_store_i) begin
          start_req = 1'b1;
          state_d   = ST_STORE;
        end
      end
      ST_DELAY: begin
        if (line_hi) begin
          state_d = ST_IDLE;
        end else if (dly_done && !acc_busy_i) begin
          if (dirty_q) begin
            start_req = 1'b1;
            state_d   = ST_STORE;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_STORE: begin
        if (eng_done) state_d = ST_HOLD;
      end
      default: state_d = ST_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_HIGH;
    else        state_q <= state_d;
  end

  assign wr_ready_o = (state_q == ST_IDLE) && line_hi && !sw_store_i;
  assign wr_fire    = wr_valid_i && wr_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          dirty_q <= 1'b0;
    else if (wr_fire)                    dirty_q <= 1'b1;
    else if (eng_done || recall_done_i)  dirty_q <= 1'b0;
  end

  assign line_pull_o   = (state_q == ST_STORE) && eng_busy;
  assign dev_en_o      = (state_q == ST_IDLE) || (state_q == ST_DELAY);
  assign store_start_o = start_req;
  assign store_done_o  = eng_done;
endmodule

// File: rtl/hsa_checker.sv
module hsa_checker (
  input logic clk,
  input logic rst_n,
  input logic line_pull_o,
  input logic dev_en_o,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic store_start_o,
  input logic store_done_o,
  input logic sw_store_i,
  input logic acc_busy_i,
  input logic dirty
);
  // R5
  pull_only_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_o |-> !dev_en_o);

  // R4
  write_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o) |-> (dev_en_o && !line_pull_o));

  // R2
  start_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start_o && !sw_store_i) |-> dirty);

  // R3
  start_waits_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start_o && !sw_store_i) |-> !acc_busy_i);

  // R5
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start_o |=> !store_start_o);

  // R6
  done_then_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_done_o |=> (!dev_en_o && !line_pull_o));

  // R7
  done_clears_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_done_o |=> !dirty);
endmodule

bind hw_store_arbiter hsa_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_pull_o   (line_pull_o),
  .dev_en_o      (dev_en_o),
  .wr_valid_i    (wr_valid_i),
  .wr_ready_o    (wr_ready_o),
  .store_start_o (store_start_o),
  .store_done_o  (store_done_o),
  .sw_store_i    (sw_store_i),
  .acc_busy_i    (acc_busy_i),
  .dirty         (dirty_q)
);

// File: tb/hw_store_arbiter_bench.sv
`timescale 1ns/1ps
module hw_store_arbiter_bench;
  localparam int DELAY_CYC = 8;
  localparam int STORE_CYC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pull = 1'b0;
  logic sw_store = 1'b0, acc_busy = 1'b0, wr_valid = 1'b0, recall_done = 1'b0;
  logic line_pull, wr_ready, dev_en, store_start, store_done;
  logic line_level;

  int n_checks = 0;
  int n_fail = 0;
  int start_cnt = 0;
  int pull_cnt = 0;

  always #2 clk = ~clk;

  assign line_level = ~(ext_pull | line_pull);

  hw_store_arbiter #(.DELAY_CYC(DELAY_CYC), .STORE_CYC(STORE_CYC)) u_hw_store_arbiter (
    .clk(clk), .rst_n(rst_n), .line_sense_i(line_level), .line_pull_o(line_pull),
    .sw_store_i(sw_store), .acc_busy_i(acc_busy), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .recall_done_i(recall_done), .dev_en_o(dev_en),
    .store_start_o(store_start), .store_done_o(store_done)
  );

  always @(negedge clk) begin
    if (store_start) start_cnt++;
    if (line_pull)   pull_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write();
    @(negedge clk);
    wr_valid = 1'b1;
    #0.1;
    chk(wr_ready == 1'b1, "R7 write accepted when idle", wr_ready, 1);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Pull the line, wait until a start pulse or the no-store wait, then release.
  task automatic hw_request(output bit started, output int gap, output int pulls);
    int s0 = start_cnt;
    int p0 = pull_cnt;
    started = 1'b0;
    gap = 0;
    @(negedge clk);
    ext_pull = 1'b1;
    for (int i = 0; i < DELAY_CYC + 40; i++) begin
      @(negedge clk);
      gap++;
      if (store_start) begin started = 1'b1; break; end
      if (!dev_en && !line_pull && i > DELAY_CYC + 3) break;
    end
    cyc(STORE_CYC + 6);
    pulls = pull_cnt - p0;
    chk(!dev_en, "R6 disabled while line held low after request", dev_en, 0);
    chk(start_cnt - s0 == int'(started), "R5 single start pulse", start_cnt - s0, int'(started));
    ext_pull = 1'b0;
    cyc(5);
    chk(dev_en, "R6 enabled again after line high", dev_en, 1);
  endtask

  task automatic t_reset();
    chk(!line_pull && !store_start, "R9 no pull or start in reset", line_pull, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dev_en && !wr_ready, "R9 disabled until line seen high", dev_en, 0);
    cyc(4);
    chk(dev_en, "R9 enabled once line seen high", dev_en, 1);
  endtask

  task automatic t_clean_request();
    bit st; int g, p;
    hw_request(st, g, p);
    chk(!st, "R2 no store when clean", st, 0);
    chk(p == 0, "R2 no pull when clean", p, 0);
  endtask

  task automatic t_dirty_request();
    bit st; int g, p;
    do_write();
    hw_request(st, g, p);
    chk(st, "R2 store when dirty", st, 1);
    chk(g >= DELAY_CYC && g <= DELAY_CYC + 4, "R1 start after delay", g, DELAY_CYC + 3);
    chk(p == STORE_CYC, "R5 pull length equals store time", p, STORE_CYC);
    hw_request(st, g, p);
    chk(!st, "R7 store clears dirty", st, 0);
  endtask

  task automatic t_blocked_write();
    bit st; int g, p;
    @(negedge clk);
    ext_pull = 1'b1;
    cyc(4);
    wr_valid = 1'b1;
    #0.1;
    chk(!wr_ready, "R4 write blocked while line low", wr_ready, 0);
    cyc(2);
    wr_valid = 1'b0;
    ext_pull = 1'b0;
    cyc(DELAY_CYC + 10);
    hw_request(st, g, p);
    chk(!st, "R4 blocked write left array clean", st, 0);
  endtask

  task automatic t_access_hold();
    int s0;
    do_write();
    acc_busy = 1'b1;
    s0 = start_cnt;
    @(negedge clk);
    ext_pull = 1'b1;
    cyc(DELAY_CYC + 12);
    chk(start_cnt == s0, "R3 start held while access busy", start_cnt - s0, 0);
    acc_busy = 1'b0;
    cyc(2);
    chk(start_cnt == s0 + 1, "R3 start after access ends", start_cnt - s0, 1);
    cyc(STORE_CYC + 4);
    ext_pull = 1'b0;
    cyc(5);
  endtask

  task automatic t_recall_clears();
    bit st; int g, p;
    do_write();
    @(negedge clk);
    recall_done = 1'b1;
    @(negedge clk);
    recall_done = 1'b0;
    hw_request(st, g, p);
    chk(!st, "R7 recall clears dirty", st, 0);
  endtask

  task automatic t_sw_store();
    int p0 = pull_cnt;
    @(negedge clk);
    sw_store = 1'b1;
    #0.1;
    chk(store_start, "R8 software store starts when clean", store_start, 1);
    @(negedge clk);
    sw_store = 1'b0;
    chk(line_pull, "R5 line pulled during software store", line_pull, 1);
    cyc(STORE_CYC + 8);
    chk(pull_cnt - p0 == STORE_CYC, "R5 software store pull length", pull_cnt - p0, STORE_CYC);
    chk(dev_en, "R6 enabled after line returns high", dev_en, 1);
  endtask

  task automatic t_withdraw();
    bit st; int g, p;
    int s0;
    do_write();
    s0 = start_cnt;
    @(negedge clk);
    ext_pull = 1'b1;
    cyc(4);
    ext_pull = 1'b0;
    cyc(DELAY_CYC + 10);
    chk(start_cnt == s0, "R1 withdrawn request starts nothing", start_cnt - s0, 0);
    chk(dev_en, "R1 device stays enabled on withdraw", dev_en, 1);
    hw_request(st, g, p);
    chk(st, "R7 dirty kept after withdraw", st, 1);
  endtask

  task automatic t_low_at_reset();
    int s0 = start_cnt;
    @(negedge clk);
    rst_n = 1'b0;
    ext_pull = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(DELAY_CYC + 10);
    chk(!dev_en && !wr_ready, "R9 stays disabled with line low", dev_en, 0);
    chk(start_cnt == s0, "R9 no store with line low at reset", start_cnt - s0, 0);
    ext_pull = 1'b0;
    cyc(5);
    chk(dev_en, "R9 enabled after line released", dev_en, 1);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_clean_request();
    t_dirty_request();
    t_blocked_write();
    t_access_hold();
    t_recall_clears();
    t_sw_store();
    t_withdraw();
    t_low_at_reset();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule